// File: doc/BRIEF.md
# MSI Message Issuer with Pending Replay

This block turns interrupt requests from a PCI function into message-signalled interrupt memory writes. A requester presents a vector number. The block checks it against the enable bit, the enabled vector count and the per-vector mask. It then either sends a write request carrying the composed address, data word and requester ID, or records the vector as pending. The message data is the 16-bit data register, with its low log2(N) bits replaced by the vector number.

The pending bits are stored outside the block. The block reads them through `pend_i` and changes them only through one-cycle set and clear strobes. After every configuration write, while MSI is enabled and per-vector masking is supported, the block does two things. First, it drops pending bits that now lie outside the enabled range. Second, it walks vectors 0 to N-1 in ascending order. For each vector that is pending and unmasked, it clears the pending bit and sends that vector's message. Only one write is in flight at a time. Replay takes precedence over new requests.

Top module: `msi_issuer`

## Requirements
- R1: The write address is {32'h0, addr_lo} when `cfg_addr64` is 0 and {addr_hi, addr_lo} when it is 1, with address bits [1:0] forced to zero. `wr_rid` carries `rid` as it was when the write was issued.
- R2: With N = 2^k enabled vectors, `wr_data[31:16]` is zero. `wr_data[15:k]` equals `cfg_data[15:k]`, and `wr_data[k-1:0]` is the vector number. With N = 1 all 16 data bits pass through unchanged.
- R3: When masking is supported (`cfg_mask_cap`=1) and `cfg_mask[v]` is 1, an accepted request for vector v raises bit v of `pend_set_o` (one-hot) and issues no write. Repeating the request while the vector is still pending and masked leaves only that same bit set and issues nothing.
- R4: When `cfg_mask_cap`=0, the mask bits are ignored: every legal enabled request issues a write, and a configuration write starts no replay and changes no pending bit.
- R5: A `cfg_wr` pulse with `cfg_enable`=1 and `cfg_mask_cap`=1 starts a scan from vector 0 upward. For each pending, unmasked vector, the scan pulses that bit of `pend_clr_o` in the same cycle it loads the write, so messages leave in ascending vector order.
- R6: A request with vector >= N while enabled raises `err_o` in its accept cycle and produces neither a write nor a pending set.
- R7: A request accepted while `cfg_enable`=0 is dropped: no write, no pending set, no error.
- R8: `wr_valid`, once high, stays high with a stable address and data until `wr_ack`. `req_ready` is low while a write is outstanding or a replay scan is running.
- R9: A vector-count field above log2(MAX_VEC) is treated as log2(MAX_VEC).
- R10: A configuration write that starts a replay also pulses `pend_clr_o` for every vector at or above N in that cycle.
- R11: After reset, `wr_valid` and `err_o` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request present |
| req_vec | input | VW | Requested vector number |
| req_ready | output | 1 | Request accepted this cycle when high |
| err_o | output | 1 | Out-of-range vector pulse |
| cfg_enable | input | 1 | MSI enable |
| cfg_addr64 | input | 1 | 64-bit address in use |
| cfg_mask_cap | input | 1 | Per-vector masking supported |
| cfg_log_vec | input | 3 | log2 of enabled vector count |
| cfg_addr_lo | input | 32 | Message address low word |
| cfg_addr_hi | input | 32 | Message address high word |
| cfg_data | input | 16 | Message data base |
| cfg_mask | input | MAX_VEC | Per-vector mask bits |
| cfg_wr | input | 1 | Configuration write occurred |
| rid | input | RID_W | Requester ID of the function |
| pend_i | input | MAX_VEC | Current pending bits |
| pend_set_o | output | MAX_VEC | Pending set strobes |
| pend_clr_o | output | MAX_VEC | Pending clear strobes |
| wr_valid | output | 1 | Write request outstanding |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data |
| wr_rid | output | RID_W | Requester ID for the write |
| wr_ack | input | 1 | Write accepted |

## Verification
The bench builds the block with MAX_VEC=8. A vector-count field of 4 to 7 therefore lies above the supported maximum, which exercises the clamp. With eight vectors, the bench can also shrink N to 2 and reach out-of-range requests and the trimming of upper pending bits. The bench keeps the pending bits in its own register, updated from the set and clear strobes. Replay order and the test-and-clear behaviour are then observed through `pend_i` and the sequence of write requests.

// File: rtl/msi_issuer.sv
module msi_issuer #(
  parameter int MAX_VEC = 32,
  parameter int RID_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [((MAX_VEC>1)?$clog2(MAX_VEC):1)-1:0] req_vec,
  output logic               req_ready,
  output logic               err_o,
  input  logic               cfg_enable,
  input  logic               cfg_addr64,
  input  logic               cfg_mask_cap,
  input  logic [2:0]         cfg_log_vec,
  input  logic [31:0]        cfg_addr_lo,
  input  logic [31:0]        cfg_addr_hi,
  input  logic [15:0]        cfg_data,
  input  logic [MAX_VEC-1:0] cfg_mask,
  input  logic               cfg_wr,
  input  logic [RID_W-1:0]   rid,
  input  logic [MAX_VEC-1:0] pend_i,
  output logic [MAX_VEC-1:0] pend_set_o,
  output logic [MAX_VEC-1:0] pend_clr_o,
  output logic               wr_valid,
  output logic [63:0]        wr_addr,
  output logic [31:0]        wr_data,
  output logic [RID_W-1:0]   wr_rid,
  input  logic               wr_ack
);

  localparam int VW      = (MAX_VEC > 1) ? $clog2(MAX_VEC) : 1;
  localparam int CW      = VW + 1;
  localparam int LOG_MAX = $clog2(MAX_VEC);
  localparam logic [MAX_VEC-1:0] ONE = {{(MAX_VEC-1){1'b0}}, 1'b1};

  logic [2:0]         eff_log;
  logic [CW-1:0]      nvec;
  logic [MAX_VEC-1:0] in_range;
  logic               scanning;
  logic [VW-1:0]      scan_idx;

  assign eff_log = (cfg_log_vec > 3'(LOG_MAX)) ? 3'(LOG_MAX) : cfg_log_vec;
  assign nvec    = CW'(1) << eff_log;

  always_comb
    for (int i = 0; i < MAX_VEC; i++)
      in_range[i] = (CW'(i) < nvec);

  logic accept, req_ok, req_masked, req_set, req_fire;
  assign req_ready  = !wr_valid && !scanning;
  assign accept     = req_valid && req_ready;
  assign req_ok     = {1'b0, req_vec} < nvec;
  assign req_masked = cfg_mask_cap && cfg_mask[req_vec];
  assign err_o      = accept && cfg_enable && !req_ok;
  assign req_set    = accept && cfg_enable && req_ok && req_masked;
  assign req_fire   = accept && cfg_enable && req_ok && !req_masked;

  logic scan_go, scan_hit, scan_last, replay_trig;
  assign scan_go     = scanning && !wr_valid;
  assign scan_hit    = scan_go && pend_i[scan_idx] && !cfg_mask[scan_idx];
  assign scan_last   = ({1'b0, scan_idx} >= nvec - CW'(1));
  assign replay_trig = cfg_wr && cfg_enable && cfg_mask_cap;

  assign pend_set_o = req_set ? (ONE << req_vec) : '0;
  assign pend_clr_o = (replay_trig ? ~in_range : '0) |
                      (scan_hit ? (ONE << scan_idx) : '0);

  logic          issue;
  logic [VW-1:0] issue_vec;
  logic [15:0]   vmask;
  assign issue     = req_fire || scan_hit;
  assign issue_vec = scan_hit ? scan_idx : req_vec;
  assign vmask     = 16'(nvec - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_rid   <= '0;
      scanning <= 1'b0;
      scan_idx <= '0;
    end else begin
      if (wr_valid && wr_ack) wr_valid <= 1'b0;
      if (issue) begin
        wr_valid <= 1'b1;
        wr_addr  <= {cfg_addr64 ? cfg_addr_hi : 32'h0, cfg_addr_lo[31:2], 2'b00};
        wr_data  <= {16'h0, (cfg_data & ~vmask) | (16'(issue_vec) & vmask)};
        wr_rid   <= rid;
      end
      if (!cfg_enable || !cfg_mask_cap) scanning <= 1'b0;
      else if (scan_go) begin
        scan_idx <= scan_idx + VW'(1);
        if (scan_last) scanning <= 1'b0;
      end
      if (replay_trig) begin
        scanning <= 1'b1;
        scan_idx <= '0;
      end
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !req_ready); // R8
  AST_SET_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set_o) |-> (cfg_mask_cap && cfg_enable)); // R3
  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_set_o)); // R3
  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !wr_valid); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable && !wr_valid |=> !wr_valid); // R7

endmodule

// File: tb/msi_issuer_tb_top.sv
`timescale 1ns/1ps
module msi_issuer_tb_top;
  localparam int MV = 8;
  localparam int VW = 3;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready, err_o;
  logic [VW-1:0] req_vec = '0;
  logic cfg_enable = 0, cfg_addr64 = 0, cfg_mask_cap = 0, cfg_wr = 0;
  logic [2:0] cfg_log_vec = 0;
  logic [31:0] cfg_addr_lo = 0, cfg_addr_hi = 0;
  logic [15:0] cfg_data = 0;
  logic [MV-1:0] cfg_mask = 0, pend, pend_set_o, pend_clr_o;
  logic [15:0] rid = 16'hBEEF;
  logic wr_valid, wr_ack = 0;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;
  logic [15:0] wr_rid;

  int checks = 0, fails = 0;
  logic cap_err;
  logic [MV-1:0] cap_set;

  msi_issuer #(.MAX_VEC(MV), .RID_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_ready(req_ready), .err_o(err_o), .cfg_enable(cfg_enable),
    .cfg_addr64(cfg_addr64), .cfg_mask_cap(cfg_mask_cap), .cfg_log_vec(cfg_log_vec),
    .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
    .cfg_mask(cfg_mask), .cfg_wr(cfg_wr), .rid(rid), .pend_i(pend),
    .pend_set_o(pend_set_o), .pend_clr_o(pend_clr_o), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_rid(wr_rid), .wr_ack(wr_ack));

  always_ff @(posedge clk)
    if (!rst_n) pend <= '0;
    else pend <= (pend | pend_set_o) & ~pend_clr_o;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [VW-1:0] v);
    @(negedge clk);
    req_valid = 1; req_vec = v;
    #1; cap_err = err_o; cap_set = pend_set_o;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic cfg_pulse();
    @(negedge clk); cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic expect_write(input logic [63:0] ea, input logic [31:0] ed, input string rq);
    for (int i = 0; i < 20 && !wr_valid; i++) @(negedge clk);
    chk(wr_valid, rq, "write present", {63'h0, wr_valid}, 64'h1);
    chk(wr_addr == ea, rq, "address", wr_addr, ea);
    chk(wr_data == ed, rq, "data", {32'h0, wr_data}, {32'h0, ed});
    wr_ack = 1;
    @(negedge clk); wr_ack = 0;
  endtask

  task automatic expect_none(input string rq);
    bit seen = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (wr_valid) seen = 1; end
    chk(!seen, rq, "no write", {63'h0, seen}, 64'h0);
  endtask

  task automatic t_reset();
    chk(!wr_valid && req_ready && !err_o, "R11", "reset state",
        {61'h0, wr_valid, req_ready, err_o}, 64'h2);
  endtask

  task automatic t_addr32();
    cfg_enable = 1; cfg_addr64 = 0; cfg_log_vec = 0;
    cfg_addr_lo = 32'h1234_5677; cfg_addr_hi = 32'hFFFF_0000; cfg_data = 16'hABCD;
    do_req(0);
    expect_write(64'h0000_0000_1234_5674, 32'h0000_ABCD, "R1");
    chk(wr_rid == 16'hBEEF, "R1", "rid", {48'h0, wr_rid}, 64'hBEEF);
  endtask

  task automatic t_addr64_vec();
    cfg_addr64 = 1; cfg_log_vec = 3;
    do_req(2);
    expect_write(64'hFFFF_0000_1234_5674, 32'h0000_ABCA, "R2");
  endtask

  task automatic t_hold();
    logic [63:0] a0;
    bit ok = 1;
    do_req(5);
    for (int i = 0; i < 20 && !wr_valid; i++) @(negedge clk);
    a0 = wr_addr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!wr_valid || req_ready || wr_addr != a0 || wr_data != 32'hABCD) ok = 0;
    end
    chk(ok, "R8", "held until ack", {63'h0, ok}, 64'h1);
    wr_ack = 1; @(negedge clk); wr_ack = 0;
    chk(!wr_valid && req_ready, "R8", "released after ack", {63'h0, wr_valid}, 64'h0);
  endtask

  task automatic t_clamp();
    cfg_log_vec = 7;
    do_req(7);
    chk(!cap_err, "R9", "clamped count accepts 7", {63'h0, cap_err}, 64'h0);
    expect_write(64'hFFFF_0000_1234_5674, 32'h0000_ABCF, "R9");
  endtask

  task automatic t_range();
    cfg_log_vec = 1;
    do_req(3);
    chk(cap_err == 1, "R6", "err pulse", {63'h0, cap_err}, 64'h1);
    chk(cap_set == 0, "R6", "no pending set", {56'h0, cap_set}, 64'h0);
    expect_none("R6");
  endtask

  task automatic t_disabled();
    cfg_enable = 0; cfg_mask_cap = 1; cfg_mask = '1; cfg_log_vec = 3;
    do_req(1);
    chk(!cap_err && cap_set == 0, "R7", "dropped", {55'h0, cap_err, cap_set}, 64'h0);
    expect_none("R7");
    chk(pend == 0, "R7", "pending untouched", {56'h0, pend}, 64'h0);
  endtask

  task automatic t_masked();
    cfg_enable = 1; cfg_mask = 8'h08;
    do_req(3);
    chk(cap_set == 8'h08, "R3", "set strobe", {56'h0, cap_set}, 64'h08);
    expect_none("R3");
    do_req(3);
    chk(cap_set == 8'h08, "R3", "repeat set", {56'h0, cap_set}, 64'h08);
    expect_none("R3");
    chk(pend == 8'h08, "R3", "pending", {56'h0, pend}, 64'h08);
  endtask

  task automatic t_nocap();
    cfg_mask_cap = 0; cfg_mask = '1;
    do_req(4);
    expect_write(64'hFFFF_0000_1234_5674, 32'h0000_ABCC, "R4");
    cfg_pulse();
    expect_none("R4");
    chk(pend == 8'h08, "R4", "no replay", {56'h0, pend}, 64'h08);
  endtask

  task automatic t_replay();
    cfg_mask_cap = 1; cfg_mask = '1;
    do_req(1); do_req(6);
    chk(pend == 8'h4A, "R5", "setup pending", {56'h0, pend}, 64'h4A);
    cfg_mask = 8'h08;
    cfg_pulse();
    expect_write(64'hFFFF_0000_1234_5674, 32'h0000_ABC9, "R5");
    chk(!pend[1], "R5", "bit1 cleared", {56'h0, pend}, 64'h48);
    expect_write(64'hFFFF_0000_1234_5674, 32'h0000_ABCE, "R5");
    expect_none("R5");
    chk(pend == 8'h08, "R5", "masked stays", {56'h0, pend}, 64'h08);
  endtask

  task automatic t_trim();
    cfg_mask = '1;
    do_req(6);
    chk(pend == 8'h48, "R10", "setup", {56'h0, pend}, 64'h48);
    cfg_log_vec = 1;
    cfg_pulse();
    expect_none("R10");
    chk(pend == 8'h00, "R10", "upper cleared", {56'h0, pend}, 64'h0);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_addr32(); t_addr64_vec(); t_hold(); t_clamp(); t_range();
    t_disabled(); t_masked(); t_nocap(); t_replay(); t_trim();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule